// File: doc/BRIEF.md
# Maskable LAM Interrupt Register Set

This block is the host-side event and interrupt register set of a serial highway driver. Twelve single-cycle event pulses from the transmit/receive engine are latched as sticky status flags. Each flag is then gated by a mask bit. When any unmasked flag is pending and the global interrupt enable is set, one level interrupt request is raised.

A simple register bus with a 2-bit address reaches four words: a condition word, the mask register, the interrupt vector and the status register. Control bits in the written data choose between bulk and selective clearing of the status flags, and between bulk clear, selective clear and selective set of the mask bits. Writes to the status word also load the 16-bit vector.

The condition word holds a booking bit that acts as a read-to-claim semaphore for several bus masters. It also holds the global enable, a summary of the masked flags, and copies of four key status flags. A synchronous programmed reset clears everything, in the same way as the asynchronous bus reset.

Top module: `lam_irq_regs`

## Requirements
- R1: After reset, the status, mask and vector read as zero, `irq_o` is 0, and the condition word reads 0x0000_0002 (booking bit 0 clear, bit 1 set as its complement).
- R2: An event pulse on bit i of `event_i` sets status flag i in the next cycle. The flag holds until a status write clears it. Flags 8, 9, 10 and 11 are sequence complete, transmission finished, demand received and sync lost.
- R3: A write to the status address (3) with bit 12 = 0 clears every flag. With bit 12 = 1 it clears only the flags whose positions hold 1 in bits 11:0.
- R4: If an event pulse and a status clear hit the same flag in the same cycle, the flag ends up set.
- R5: A write to the mask address (1) with bit 12 = 1 clears all twelve mask bits.
- R6: A mask write with bit 12 = 0 and bit 13 = 1 clears the mask bits marked by 1s in bits 11:0. A mask write with bits 12 and 13 = 0 and bit 14 = 1 sets those bits.
- R7: Every status write loads bits 31:16 into the vector. A read of address 2 returns the vector in bits 31:16 and zero in bits 15:0.
- R8: Writing the condition address (0) with bit 4 = 1 sets the global enable, which reads back at condition bit 4. Writing bit 4 = 0 leaves it unchanged. A pulse on `mbox_ack_i` clears it, and it wins over a simultaneous set.
- R9: Condition bit 7 reads 1 exactly when some status flag and its mask bit are both 1.
- R10: `irq_o` is 1 exactly when the global enable is set and a masked flag is pending. It drops in the cycle after either condition goes false.
- R11: A read of the condition word while the booking bit is 0 returns bit 0 = 0 and sets the bit. Later reads return bit 0 = 1 and bit 1 = 0. Writing the condition word with bit 0 = 1 clears the booking bit.
- R12: A pulse on `soft_rst_i` clears the status, mask, vector, global enable and booking bit in the next cycle.
- R13: Condition bits 5, 6, 8 and 9 mirror status flags 9, 8, 11 and 10 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| soft_rst_i | input | 1 | Synchronous programmed reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Word select: 0 condition, 1 mask, 2 vector, 3 status |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| event_i | input | 12 | Event pulses, one cycle each |
| mbox_ack_i | input | 1 | Vector handed back to the mailbox; drops the enable |
| irq_o | output | 1 | Level interrupt request |

## Verification
The assertions assume that reads and writes are never strobed in the same cycle. They also assume that `event_i` carries one-cycle pulses that are meaningful only out of reset. The bench keeps to this by driving every bus access as a single-cycle strobe, with only one access per cycle. Event pulses are driven either alone or combined with one status write, which is how the set-versus-clear collision is produced on purpose.

// File: rtl/lam_irq_pkg.sv
package lam_irq_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned VEC_W  = 16;

  typedef enum logic [1:0] {
    ADR_COND = 2'd0,
    ADR_MASK = 2'd1,
    ADR_VEC  = 2'd2,
    ADR_STAT = 2'd3
  } reg_addr_e;

  // condition word bit positions
  localparam int unsigned CB_BOOK  = 0;
  localparam int unsigned CB_FREE  = 1;
  localparam int unsigned CB_INTEN = 4;
  localparam int unsigned CB_XMR   = 5;
  localparam int unsigned CB_SHR   = 6;
  localparam int unsigned CB_LAM   = 7;
  localparam int unsigned CB_SYNC  = 8;
  localparam int unsigned CB_DMD   = 9;

  // status flags mirrored into the condition word
  localparam int unsigned EV_SHR  = 8;
  localparam int unsigned EV_XMR  = 9;
  localparam int unsigned EV_DMD  = 10;
  localparam int unsigned EV_SERR = 11;
endpackage

// File: rtl/lam_status_reg.sv
module lam_status_reg #(
  parameter int unsigned N_EVT = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_i,
  input  logic             wr_i,
  input  logic [N_EVT:0]   wdata_i,
  input  logic [N_EVT-1:0] event_i,
  output logic [N_EVT-1:0] status_o
);
  localparam int unsigned SEL_BIT = N_EVT;

  logic [N_EVT-1:0] status_q, clr_vec;

  always_comb begin
    clr_vec = '0;
    if (wr_i) clr_vec = wdata_i[SEL_BIT] ? wdata_i[N_EVT-1:0] : '1;
  end

  // set after clear: a coincident event survives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         status_q <= '0;
    else if (soft_rst_i) status_q <= '0;
    else                 status_q <= (status_q & ~clr_vec) | event_i;
  end

  assign status_o = status_q;
endmodule

// File: rtl/lam_mask_reg.sv
module lam_mask_reg #(
  parameter int unsigned N_EVT = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_i,
  input  logic             wr_i,
  input  logic [N_EVT+2:0] wdata_i,
  output logic [N_EVT-1:0] mask_o
);
  localparam int unsigned CLR_ALL = N_EVT;
  localparam int unsigned CLR_SEL = N_EVT + 1;
  localparam int unsigned SET_SEL = N_EVT + 2;

  logic clr_all, clr_sel, set_sel;
  assign clr_all = wr_i && wdata_i[CLR_ALL];
  assign clr_sel = wr_i && !wdata_i[CLR_ALL] && wdata_i[CLR_SEL];
  assign set_sel = wr_i && !wdata_i[CLR_ALL] && !wdata_i[CLR_SEL] && wdata_i[SET_SEL];

  for (genvar i = 0; i < N_EVT; i++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         bit_q <= 1'b0;
      else if (soft_rst_i || clr_all)      bit_q <= 1'b0;
      else if (clr_sel && wdata_i[i])      bit_q <= 1'b0;
      else if (set_sel && wdata_i[i])      bit_q <= 1'b1;
    end
    assign mask_o[i] = bit_q;
  end
endmodule

// File: rtl/lam_cond_ctrl.sv
module lam_cond_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic soft_rst_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic book_clr_i,
  input  logic inten_set_i,
  input  logic mbox_ack_i,
  output logic book_o,
  output logic inten_o
);
  logic book_q, inten_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  book_q <= 1'b0;
    else if (soft_rst_i)          book_q <= 1'b0;
    else if (wr_i && book_clr_i)  book_q <= 1'b0;
    else if (rd_i)                book_q <= 1'b1;
  end

  // mailbox hand-back outranks a same-cycle enable write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      inten_q <= 1'b0;
    else if (soft_rst_i || mbox_ack_i) inten_q <= 1'b0;
    else if (wr_i && inten_set_i)     inten_q <= 1'b1;
  end

  assign book_o  = book_q;
  assign inten_o = inten_q;
endmodule

// File: rtl/lam_irq_regs.sv
module lam_irq_regs
  import lam_irq_pkg::*;
#(
  parameter int unsigned N_EVT = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_EVT-1:0]  event_i,
  input  logic              mbox_ack_i,
  output logic              irq_o
);
  localparam int unsigned VEC_LSB = DATA_W - VEC_W;

  logic [N_EVT-1:0] status_w, mask_w;
  logic [VEC_W-1:0] vec_q;
  logic             book_w, inten_w, lam_any;
  logic             wr_cond, wr_mask, wr_stat, rd_cond;
  logic             unused_wdata;

  assign wr_cond = wr_en_i && (addr_i == ADR_COND);
  assign wr_mask = wr_en_i && (addr_i == ADR_MASK);
  assign wr_stat = wr_en_i && (addr_i == ADR_STAT);
  assign rd_cond = rd_en_i && (addr_i == ADR_COND);
  assign unused_wdata = ^wdata_i;

  lam_status_reg #(.N_EVT(N_EVT)) u_status (
    .clk_i, .rst_ni, .soft_rst_i,
    .wr_i     (wr_stat),
    .wdata_i  (wdata_i[N_EVT:0]),
    .event_i,
    .status_o (status_w)
  );

  lam_mask_reg #(.N_EVT(N_EVT)) u_mask (
    .clk_i, .rst_ni, .soft_rst_i,
    .wr_i    (wr_mask),
    .wdata_i (wdata_i[N_EVT+2:0]),
    .mask_o  (mask_w)
  );

  lam_cond_ctrl u_cond (
    .clk_i, .rst_ni, .soft_rst_i,
    .rd_i        (rd_cond),
    .wr_i        (wr_cond),
    .book_clr_i  (wdata_i[CB_BOOK]),
    .inten_set_i (wdata_i[CB_INTEN]),
    .mbox_ack_i,
    .book_o      (book_w),
    .inten_o     (inten_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         vec_q <= '0;
    else if (soft_rst_i) vec_q <= '0;
    else if (wr_stat)    vec_q <= wdata_i[DATA_W-1:VEC_LSB];
  end

  assign lam_any = |(status_w & mask_w);
  assign irq_o   = inten_w && lam_any;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADR_COND: begin
        rdata_o[CB_BOOK]  = book_w;
        rdata_o[CB_FREE]  = !book_w;
        rdata_o[CB_INTEN] = inten_w;
        rdata_o[CB_XMR]   = status_w[EV_XMR];
        rdata_o[CB_SHR]   = status_w[EV_SHR];
        rdata_o[CB_LAM]   = lam_any;
        rdata_o[CB_SYNC]  = status_w[EV_SERR];
        rdata_o[CB_DMD]   = status_w[EV_DMD];
      end
      ADR_MASK: rdata_o[N_EVT-1:0] = mask_w;
      ADR_VEC:  rdata_o[DATA_W-1:VEC_LSB] = vec_q;
      ADR_STAT: rdata_o[N_EVT-1:0] = status_w;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/lam_irq_regs_chk.sv
module lam_irq_regs_chk
  import lam_irq_pkg::*;
#(
  parameter int unsigned N_EVT = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              soft_rst_i,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [1:0]        addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [N_EVT-1:0]  event_i,
  input logic              mbox_ack_i,
  input logic              irq_o,
  input logic [N_EVT-1:0]  status_q,
  input logic [N_EVT-1:0]  mask_q,
  input logic              inten_q,
  input logic              book_q
);
  // R2 R4
  evt_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|event_i && !soft_rst_i) |=> ((status_q & $past(event_i)) == $past(event_i)));

  // R5
  mask_clr_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADR_MASK && wdata_i[N_EVT] && !soft_rst_i) |=> (mask_q == '0));

  // R7
  vec_low_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADR_VEC) |-> (rdata_o[DATA_W-VEC_W-1:0] == '0));

  // R8
  mbox_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mbox_ack_i |=> (!inten_q && !irq_o));

  // R10
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (inten_q && (status_q & mask_q) != '0));

  // R11
  book_claim_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !wr_en_i && addr_i == ADR_COND && !soft_rst_i) |=> book_q);

  // R12
  soft_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (status_q == '0 && mask_q == '0 && !inten_q && !book_q && !irq_o));
endmodule

bind lam_irq_regs lam_irq_regs_chk #(.N_EVT(N_EVT)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .soft_rst_i (soft_rst_i),
  .wr_en_i    (wr_en_i),
  .rd_en_i    (rd_en_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .event_i    (event_i),
  .mbox_ack_i (mbox_ack_i),
  .irq_o      (irq_o),
  .status_q   (status_w),
  .mask_q     (mask_w),
  .inten_q    (inten_w),
  .book_q     (book_w)
);

// File: tb/lam_irq_regs_test.sv
module lam_irq_regs_test;
  localparam logic [1:0] A_COND = 2'd0, A_MASK = 2'd1, A_VEC = 2'd2, A_STAT = 2'd3;

  logic        clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, mbox = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [11:0] evt = '0;
  logic        irq;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } rd_item_t;
  rd_item_t sb_q[$];

  always #4 clk = ~clk;

  lam_irq_regs uut (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .event_i(evt),
    .mbox_ack_i(mbox), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: one-cycle strobes set at negedge, dropped after posedge
  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [11:0] e = '0);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d; evt = e;
    @(posedge clk); #1; wr_en = 1'b0; evt = '0;
  endtask

  task automatic pulse(input logic [11:0] e);
    @(negedge clk); evt = e;
    @(posedge clk); #1; evt = '0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); rd_en = 1'b1; addr = a;
    sb_q.push_back('{exp, tag});
    @(posedge clk); #1; rd_en = 1'b0;
  endtask

  task automatic irq_chk(input logic exp, input string tag);
    @(negedge clk); #3;
    chk(tag, {31'b0, irq}, {31'b0, exp});
  endtask

  task automatic ctl(input bit m, input bit s);
    @(negedge clk); mbox = m; soft_rst = s;
    @(posedge clk); #1; mbox = 1'b0; soft_rst = 1'b0;
  endtask

  // monitor: pops expected read data and compares
  initial forever begin
    @(negedge clk); #3;
    if (rd_en) begin
      rd_item_t it;
      it = sb_q.pop_front();
      chk(it.tag, rdata, it.exp);
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    rd(A_MASK, 32'h0, "R1 mask");
    rd(A_STAT, 32'h0, "R1 status");
    rd(A_VEC,  32'h0, "R1 vector");
    irq_chk(1'b0, "R1 irq");
    rd(A_COND, 32'h2, "R1 R11 first read");
    rd(A_COND, 32'h1, "R11 booked");
    wr(A_COND, 32'h1);
    rd(A_COND, 32'h2, "R11 released");
    wr(A_COND, 32'h1);

    pulse(12'h005);
    rd(A_STAT, 32'h005, "R2 set");
    pulse(12'h800);
    rd(A_STAT, 32'h805, "R2 sticky");
    rd(A_COND, 32'h102, "R13 sync copy");
    wr(A_COND, 32'h1);

    wr(A_STAT, 32'h0000_1004);
    rd(A_STAT, 32'h801, "R3 selective");
    wr(A_STAT, 32'h0000_0000);
    rd(A_STAT, 32'h0, "R3 all");

    pulse(12'h020);
    wr(A_STAT, 32'h0000_1030, 12'h010);
    rd(A_STAT, 32'h010, "R4 set wins");

    wr(A_MASK, 32'h0000_40F0);
    rd(A_MASK, 32'h0F0, "R6 set");
    wr(A_MASK, 32'h0000_2030);
    rd(A_MASK, 32'h0C0, "R6 clear");
    wr(A_MASK, 32'h0000_4001);
    rd(A_MASK, 32'h0C1, "R6 set more");
    wr(A_MASK, 32'h0000_1000);
    rd(A_MASK, 32'h0, "R5 clear all");
    wr(A_MASK, 32'h0000_4010);

    rd(A_COND, 32'h82, "R9 summary");
    wr(A_COND, 32'h1);
    irq_chk(1'b0, "R10 enable off");
    wr(A_COND, 32'h10);
    irq_chk(1'b1, "R8 R10 raised");
    rd(A_COND, 32'h92, "R8 enable bit");
    wr(A_COND, 32'h1);
    irq_chk(1'b1, "R8 bit4=0 no effect");
    wr(A_STAT, 32'h0000_1010);
    irq_chk(1'b0, "R10 drop on clear");
    pulse(12'h010);
    irq_chk(1'b1, "R10 re-raise");
    wr(A_MASK, 32'h0000_2010);
    irq_chk(1'b0, "R10 drop on mask");
    wr(A_MASK, 32'h0000_4010);
    irq_chk(1'b1, "R10 mask back");
    ctl(1'b1, 1'b0);
    irq_chk(1'b0, "R8 mailbox clears");
    rd(A_COND, 32'h82, "R8 enable gone");
    wr(A_COND, 32'h1);

    wr(A_STAT, 32'hABCD_1000);
    rd(A_VEC,  32'hABCD_0000, "R7 vector");
    rd(A_STAT, 32'h010, "R7 status untouched");

    wr(A_STAT, 32'h0);
    pulse(12'h700);
    rd(A_COND, 32'h262, "R13 copies");
    wr(A_COND, 32'h1);

    pulse(12'h0FF);
    wr(A_MASK, 32'h0000_4FFF);
    wr(A_COND, 32'h10);
    irq_chk(1'b1, "R12 pre");
    ctl(1'b0, 1'b1);
    irq_chk(1'b0, "R12 irq");
    rd(A_STAT, 32'h0, "R12 status");
    rd(A_MASK, 32'h0, "R12 mask");
    rd(A_VEC,  32'h0, "R12 vector");
    rd(A_COND, 32'h2, "R12 condition");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule